// File: doc/BRIEF.md
# Programmable Multi-Bank Clock Divider

This block divides one fast source clock into three four-lane output banks and one feedback output. Each bank has its own divide ratio, set by a small select code and a shared range bit. The range bit halves or doubles every ratio together, so a single source rate can serve two frequency ranges. All ratios are even, so every output has an exact 50% duty cycle. The upper two lanes of bank C can be driven in antiphase with the lower two.

An active-high reset stops all dividers and clears them. A start sequencer has two states. `SQ_HOLD` is entered on reset. `SQ_HOLD -> SQ_RUN` fires on the first source edge that samples reset low, and `SQ_RUN` stays until reset returns. Each divider is a three-state machine:
- `DV_IDLE -> DV_HIGH` on the edge after the run flag is seen.
- `DV_HIGH -> DV_LOW` when the half-period count expires.
- `DV_LOW -> DV_HIGH` when the half-period count expires again; the ratio for the next period is latched here.
- Any state goes to `DV_IDLE` while reset is high or run is low.

The output-enable flag stands in for the drivers that a real part would switch to high impedance.

Top module: `mbdiv_banks`

## Requirements
- R1: With `range_hi`=0 every divide ratio is twice the ratio it has with `range_hi`=1.
- R2: Bank A ratios for `sel_a` codes 00/01/10/11 are 4/6/8/12 with `range_hi`=1 (8/12/16/24 with it at 0).
- R3: Bank B ratios for `sel_b` codes 00/01/10/11 are 4/6/8/10 with `range_hi`=1 (8/12/16/20 with it at 0).
- R4: Bank C ratios for `sel_c` codes 00/01/10/11 are 2/4/6/8 with `range_hi`=1 (4/8/12/16 with it at 0).
- R5: Feedback ratio for `sel_fb` codes 000..111 is 4,6,8,10,8,12,16,20 with `range_hi`=1, and double that with it at 0.
- R6: Every output is high for exactly N/2 source cycles and then low for N/2 cycles, where N is its ratio. All lanes of banks A and B, and lanes 0 and 1 of bank C, are identical.
- R7: On any edge that samples `rst`=1, all outputs and `out_en` go low and stay low while `rst` is held.
- R8: `out_en` rises on the first edge that samples `rst`=0. All non-inverted outputs rise together on the following edge.
- R9: With `invert_c`=1, lanes 2 and 3 of bank C are the complement of lanes 0 and 1 once the dividers run. With `invert_c`=0, all four lanes match.
- R10: A select change takes effect only at the next rising edge of that output. The period already in progress finishes at the old ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock |
| rst | input | 1 | Active-high synchronous reset, stops and realigns all dividers |
| range_hi | input | 1 | 1 = base ratios, 0 = all ratios doubled |
| sel_a | input | 2 | Bank A ratio select |
| sel_b | input | 2 | Bank B ratio select |
| sel_c | input | 2 | Bank C ratio select |
| sel_fb | input | 3 | Feedback ratio select |
| invert_c | input | 1 | Drive bank C upper lanes in antiphase |
| q_a | output | LANES | Bank A outputs |
| q_b | output | LANES | Bank B outputs |
| q_c | output | LANES | Bank C outputs |
| q_fb | output | 1 | Feedback output |
| out_en | output | 1 | Output-enable flag, low in reset |

## Verification
The hardest case to reach is a ratio change in the middle of a period. It needs a select input to move while a divider is partway through a long period, and the new ratio must show up only after that period closes. The stimulus starts bank A at ratio 12 and switches it to ratio 4 three cycles after the common start. It then compares every later cycle against a model in which the first 12-cycle period completes intact. A reset is then applied mid-run to show that all outputs drop together.

// File: rtl/mbdiv_pkg.sv
package mbdiv_pkg;

    typedef enum logic [1:0] {
        DV_IDLE = 2'd0,
        DV_HIGH = 2'd1,
        DV_LOW  = 2'd2
    } dv_state_t;

    typedef enum logic {
        SQ_HOLD = 1'b0,
        SQ_RUN  = 1'b1
    } sq_state_t;

    // Divider kinds, one per output group
    localparam int KIND_A  = 0;
    localparam int KIND_B  = 1;
    localparam int KIND_C  = 2;
    localparam int KIND_FB = 3;

endpackage

// File: rtl/mbdiv_ratio_decode.sv
module mbdiv_ratio_decode
    import mbdiv_pkg::*;
#(
    parameter int KIND = KIND_A,
    parameter int RW   = 6
) (
    input  logic [2:0]    sel,
    input  logic          range_hi,
    output logic [RW-1:0] ratio
);

    logic [RW-1:0] base;

    generate
        if (KIND == KIND_A) begin : g_a
            always_comb begin
                unique case (sel[1:0])
                    2'b00:   base = RW'(4);
                    2'b01:   base = RW'(6);
                    2'b10:   base = RW'(8);
                    default: base = RW'(12);
                endcase
            end
        end else if (KIND == KIND_B) begin : g_b
            always_comb begin
                unique case (sel[1:0])
                    2'b00:   base = RW'(4);
                    2'b01:   base = RW'(6);
                    2'b10:   base = RW'(8);
                    default: base = RW'(10);
                endcase
            end
        end else if (KIND == KIND_C) begin : g_c
            always_comb begin
                unique case (sel[1:0])
                    2'b00:   base = RW'(2);
                    2'b01:   base = RW'(4);
                    2'b10:   base = RW'(6);
                    default: base = RW'(8);
                endcase
            end
        end else begin : g_fb
            logic [RW-1:0] low_half;
            always_comb begin
                unique case (sel[1:0])
                    2'b00:   low_half = RW'(4);
                    2'b01:   low_half = RW'(6);
                    2'b10:   low_half = RW'(8);
                    default: low_half = RW'(10);
                endcase
                // upper select bit doubles the feedback ratio
                base = sel[2] ? (low_half << 1) : low_half;
            end
        end
    endgenerate

    // low range doubles every ratio
    assign ratio = range_hi ? base : (base << 1);

endmodule

// File: rtl/mbdiv_start_seq.sv
module mbdiv_start_seq
    import mbdiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output logic run
);

    sq_state_t state, state_n;

    always_comb begin
        state_n = state;
        unique case (state)
            SQ_HOLD: state_n = SQ_RUN;
            SQ_RUN:  state_n = SQ_RUN;
            default: state_n = SQ_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_HOLD;
        end else begin
            state <= state_n;
        end
    end

    always_comb begin
        run = (state == SQ_RUN);
    end

endmodule

// File: rtl/mbdiv_half_div.sv
module mbdiv_half_div
    import mbdiv_pkg::*;
#(
    parameter int RW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [RW-1:0] ratio,
    output logic          phase,
    output logic          active
);

    localparam logic [RW-1:0] ONE = RW'(1);

    dv_state_t     state, state_n;
    logic [RW-1:0] cnt, cnt_n;
    logic [RW-1:0] half, half_n;
    logic          wrap;

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        half_n  = half;
        wrap    = (cnt == (half - ONE));
        unique case (state)
            DV_IDLE: begin
                state_n = DV_HIGH;
                cnt_n   = '0;
                half_n  = ratio >> 1;
            end
            DV_HIGH: begin
                if (wrap) begin
                    state_n = DV_LOW;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt + ONE;
                end
            end
            DV_LOW: begin
                if (wrap) begin
                    state_n = DV_HIGH;
                    cnt_n   = '0;
                    half_n  = ratio >> 1;   // new ratio only at a rising edge
                end else begin
                    cnt_n = cnt + ONE;
                end
            end
            default: begin
                state_n = DV_IDLE;
                cnt_n   = '0;
            end
        endcase
        if (!go) begin
            state_n = DV_IDLE;
            cnt_n   = '0;
            half_n  = ratio >> 1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= DV_IDLE;
            cnt   <= '0;
            half  <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            half  <= half_n;
        end
    end

    always_comb begin
        phase  = (state == DV_HIGH);
        active = (state != DV_IDLE);
    end

endmodule

// File: rtl/mbdiv_banks.sv
module mbdiv_banks
    import mbdiv_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int MAX_RATIO = 40
) (
    input  logic             clk_src,
    input  logic             rst,
    input  logic             range_hi,
    input  logic [1:0]       sel_a,
    input  logic [1:0]       sel_b,
    input  logic [1:0]       sel_c,
    input  logic [2:0]       sel_fb,
    input  logic             invert_c,
    output logic [LANES-1:0] q_a,
    output logic [LANES-1:0] q_b,
    output logic [LANES-1:0] q_c,
    output logic             q_fb,
    output logic             out_en
);

    localparam int NUM_DIV = 4;
    localparam int RW      = $clog2(MAX_RATIO + 1);
    localparam int SPLIT   = LANES / 2;

    logic                run;
    logic [2:0]          sel_vec [NUM_DIV];
    logic [RW-1:0]       ratio   [NUM_DIV];
    logic [NUM_DIV-1:0]  phase;
    logic [NUM_DIV-1:0]  active;

    assign sel_vec[KIND_A]  = {1'b0, sel_a};
    assign sel_vec[KIND_B]  = {1'b0, sel_b};
    assign sel_vec[KIND_C]  = {1'b0, sel_c};
    assign sel_vec[KIND_FB] = sel_fb;

    mbdiv_start_seq u_seq (
        .clk (clk_src),
        .rst (rst),
        .run (run)
    );

    generate
        for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
            mbdiv_ratio_decode #(.KIND(g), .RW(RW)) u_dec (
                .sel      (sel_vec[g]),
                .range_hi (range_hi),
                .ratio    (ratio[g])
            );
            mbdiv_half_div #(.RW(RW)) u_div (
                .clk    (clk_src),
                .rst    (rst),
                .go     (run),
                .ratio  (ratio[g]),
                .phase  (phase[g]),
                .active (active[g])
            );
        end

        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign q_a[l] = phase[KIND_A];
            assign q_b[l] = phase[KIND_B];
            if (l >= SPLIT) begin : g_upper
                assign q_c[l] = invert_c ? (active[KIND_C] & ~phase[KIND_C])
                                         : phase[KIND_C];
            end else begin : g_lower
                assign q_c[l] = phase[KIND_C];
            end
        end
    endgenerate

    assign q_fb   = phase[KIND_FB];
    assign out_en = run;

endmodule

// File: rtl/mbdiv_banks_chk.sv
module mbdiv_banks_chk #(
    parameter int LANES     = 4,
    parameter int MAX_RATIO = 40
) (
    input logic             clk_src,
    input logic             rst,
    input logic             invert_c,
    input logic [LANES-1:0] q_a,
    input logic [LANES-1:0] q_b,
    input logic [LANES-1:0] q_c,
    input logic             q_fb,
    input logic             out_en
);

    localparam int LW = $clog2(MAX_RATIO + 2);

    logic          prev_fb;
    logic          seen_fall;
    logic [LW-1:0] run_len;
    logic [LW-1:0] hi_len;
    logic          fb_rise;

    assign fb_rise = q_fb && !prev_fb && seen_fall;

    always_ff @(posedge clk_src) begin
        if (rst) begin
            prev_fb   <= 1'b0;
            seen_fall <= 1'b0;
            run_len   <= '0;
            hi_len    <= '0;
        end else begin
            prev_fb <= q_fb;
            if (q_fb != prev_fb) begin
                run_len <= LW'(1);
            end else begin
                run_len <= run_len + LW'(1);
            end
            if (!q_fb && prev_fb) begin
                seen_fall <= 1'b1;
                hi_len    <= run_len;
            end
        end
    end

    // R6: the low half of each feedback period equals its high half
    a_r6_even_halves: assert property (@(posedge clk_src) disable iff (rst)
        fb_rise |-> (run_len == hi_len));

    // R7: everything quiet right after reset
    a_r7_reset_quiet: assert property (@(posedge clk_src) disable iff (rst)
        $past(rst) |-> (!out_en && q_a == '0 && q_b == '0 && q_c == '0 && !q_fb));

    // R8: common first rising edge one cycle after enable
    a_r8_common_start: assert property (@(posedge clk_src) disable iff (rst)
        $rose(out_en) |=> (q_a[0] && q_b[0] && q_c[0] && q_fb));

    // R9: antiphase lanes when inversion is on
    a_r9_inv_split: assert property (@(posedge clk_src) disable iff (rst)
        (invert_c && (q_c[0] || q_c[LANES-1])) |-> (q_c[0] != q_c[LANES-1]));

    // R9: matching lanes when inversion is off
    a_r9_inv_same: assert property (@(posedge clk_src) disable iff (rst)
        !invert_c |-> (q_c[0] == q_c[LANES-1]));

endmodule

bind mbdiv_banks mbdiv_banks_chk #(.LANES(LANES), .MAX_RATIO(MAX_RATIO)) u_chk (
    .clk_src  (clk_src),
    .rst      (rst),
    .invert_c (invert_c),
    .q_a      (q_a),
    .q_b      (q_b),
    .q_c      (q_c),
    .q_fb     (q_fb),
    .out_en   (out_en)
);

// File: tb/sim_mbdiv_banks.sv
`timescale 1ns/1ps
module sim_mbdiv_banks;

    localparam int LANES  = 4;
    localparam int WINDOW = 96;
    localparam int NVEC   = 12;

    typedef struct packed {
        logic       rng;
        logic [1:0] sa;
        logic [1:0] sb;
        logic [1:0] sc;
        logic [2:0] sfb;
        logic       inv;
        logic [7:0] na;
        logic [7:0] nb;
        logic [7:0] nc;
        logic [7:0] nfb;
    } vec_t;

    // R1..R5 ratio table: range, selects, invert, expected ratios
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 2'b00, 2'b00, 2'b00, 3'b000, 1'b0, 8'd4,  8'd4,  8'd2,  8'd4},
        '{1'b1, 2'b01, 2'b01, 2'b01, 3'b001, 1'b1, 8'd6,  8'd6,  8'd4,  8'd6},
        '{1'b1, 2'b10, 2'b10, 2'b10, 3'b010, 1'b0, 8'd8,  8'd8,  8'd6,  8'd8},
        '{1'b1, 2'b11, 2'b11, 2'b11, 3'b011, 1'b1, 8'd12, 8'd10, 8'd8,  8'd10},
        '{1'b0, 2'b00, 2'b00, 2'b00, 3'b100, 1'b0, 8'd8,  8'd8,  8'd4,  8'd16},
        '{1'b0, 2'b01, 2'b01, 2'b01, 3'b101, 1'b1, 8'd12, 8'd12, 8'd8,  8'd24},
        '{1'b0, 2'b10, 2'b10, 2'b10, 3'b110, 1'b0, 8'd16, 8'd16, 8'd12, 8'd32},
        '{1'b0, 2'b11, 2'b11, 2'b11, 3'b111, 1'b1, 8'd24, 8'd20, 8'd16, 8'd40},
        '{1'b1, 2'b00, 2'b11, 2'b01, 3'b111, 1'b1, 8'd4,  8'd10, 8'd4,  8'd20},
        '{1'b1, 2'b01, 2'b10, 2'b11, 3'b100, 1'b0, 8'd6,  8'd8,  8'd8,  8'd8},
        '{1'b1, 2'b00, 2'b00, 2'b00, 3'b101, 1'b1, 8'd4,  8'd4,  8'd2,  8'd12},
        '{1'b1, 2'b10, 2'b11, 2'b10, 3'b110, 1'b0, 8'd8,  8'd10, 8'd6,  8'd16}
    };

    logic             clk_src = 1'b0;
    logic             rst = 1'b1;
    logic             range_hi = 1'b1;
    logic [1:0]       sel_a = 2'b00;
    logic [1:0]       sel_b = 2'b00;
    logic [1:0]       sel_c = 2'b00;
    logic [2:0]       sel_fb = 3'b000;
    logic             invert_c = 1'b0;
    logic [LANES-1:0] q_a, q_b, q_c;
    logic             q_fb, out_en;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk_src = ~clk_src;

    mbdiv_banks #(.LANES(LANES), .MAX_RATIO(40)) u0 (
        .clk_src  (clk_src),
        .rst      (rst),
        .range_hi (range_hi),
        .sel_a    (sel_a),
        .sel_b    (sel_b),
        .sel_c    (sel_c),
        .sel_fb   (sel_fb),
        .invert_c (invert_c),
        .q_a      (q_a),
        .q_b      (q_b),
        .q_c      (q_c),
        .q_fb     (q_fb),
        .out_en   (out_en)
    );

    function automatic bit exp_bit(input int t, input int n);
        return (t % n) < (n / 2);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic all_quiet(input string tag);
        int act;
        act = {q_a, q_b, q_c, q_fb, out_en};
        check(act == 0, tag, act, 0);
    endtask

    // apply selects in reset, release, check the start and then WINDOW cycles
    task automatic run_vec(input vec_t v, input int idx);
        int mis_a, mis_b, mis_c, mis_u, mis_fb;
        string s;
        rst      = 1'b1;
        range_hi = v.rng;
        sel_a    = v.sa;
        sel_b    = v.sb;
        sel_c    = v.sc;
        sel_fb   = v.sfb;
        invert_c = v.inv;
        repeat (3) @(posedge clk_src);
        @(negedge clk_src);
        rst = 1'b0;
        @(posedge clk_src);
        @(negedge clk_src);
        // R8: enable up, outputs still low
        s = $sformatf("R8 vec%0d enable before first edge", idx);
        check(out_en && q_a == 0 && q_b == 0 && q_c == 0 && !q_fb, s,
              {q_a, q_b, q_c, q_fb, out_en}, 1);
        mis_a = 0; mis_b = 0; mis_c = 0; mis_u = 0; mis_fb = 0;
        for (int t = 0; t < WINDOW; t++) begin
            bit ea, eb, ec, ef;
            @(posedge clk_src);
            @(negedge clk_src);
            ea = exp_bit(t, int'(v.na));
            eb = exp_bit(t, int'(v.nb));
            ec = exp_bit(t, int'(v.nc));
            ef = exp_bit(t, int'(v.nfb));
            if (q_a != {LANES{ea}}) mis_a++;
            if (q_b != {LANES{eb}}) mis_b++;
            if (q_c[1:0] != {2{ec}}) mis_c++;
            if (q_c[3:2] != {2{v.inv ? ~ec : ec}}) mis_u++;
            if (q_fb != ef) mis_fb++;
        end
        check(mis_a == 0, $sformatf("R2 R6 vec%0d bank A mismatches", idx), mis_a, 0);
        check(mis_b == 0, $sformatf("R3 R6 vec%0d bank B mismatches", idx), mis_b, 0);
        check(mis_c == 0, $sformatf("R4 R1 vec%0d bank C mismatches", idx), mis_c, 0);
        check(mis_u == 0, $sformatf("R9 vec%0d bank C upper lanes", idx), mis_u, 0);
        check(mis_fb == 0, $sformatf("R5 vec%0d feedback mismatches", idx), mis_fb, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int mis;
        // R7: reset held
        repeat (4) @(posedge clk_src);
        @(negedge clk_src);
        all_quiet("R7 quiet while reset held");

        // R1..R6, R8, R9 vector walk
        for (int i = 0; i < NVEC; i++) begin
            run_vec(VECS[i], i);
        end

        // R10: change bank A from ratio 12 to 4 three cycles into the first period
        rst = 1'b1; range_hi = 1'b1; sel_a = 2'b11; sel_c = 2'b00;
        sel_b = 2'b00; sel_fb = 3'b000; invert_c = 1'b0;
        repeat (3) @(posedge clk_src);
        @(negedge clk_src);
        rst = 1'b0;
        @(posedge clk_src);
        mis = 0;
        for (int t = 0; t < 48; t++) begin
            bit e;
            @(posedge clk_src);
            @(negedge clk_src);
            e = (t < 12) ? exp_bit(t, 12) : exp_bit(t - 12, 4);
            if (q_a[0] != e) mis++;
            if (t == 3) sel_a = 2'b00;
        end
        check(mis == 0, "R10 select change waits for rising edge", mis, 0);

        // R7: reset in the middle of a run
        @(negedge clk_src);
        rst = 1'b1;
        @(posedge clk_src);
        @(negedge clk_src);
        all_quiet("R7 quiet one edge after mid-run reset");
        repeat (5) @(posedge clk_src);
        @(negedge clk_src);
        all_quiet("R7 quiet during long reset");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule